// File: doc/BRIEF.md
# Sequential 32-by-16 Divider with Cycle-Cost Model

This block divides a 32-bit dividend by a 16-bit divisor, either as unsigned numbers or as two's-complement numbers. It works one quotient bit per clock with a restoring shift-and-subtract unit. A normal outcome is returned as one 32-bit word: the remainder sits in the upper half and the quotient in the lower half. The block also returns a four-bit condition code and a write-back enable. A zero divisor produces a trap request instead of a result.

Besides the arithmetic, the block reports how many cycles the modelled processor would charge for the same division. That count depends on the data. In unsigned mode it follows the iteration pattern of a shift-subtract loop. In signed mode it depends on the zero bits of the quotient and on the operand signs. The count is computed alongside the division and does not depend on the block's own latency. Overflow is detected from the operands before any iteration runs, so an overflowing or zero-divisor request finishes one clock after it is accepted. A normal request finishes 33 clocks after it is accepted.

The interface is a plain control handshake with no back-pressure. A request is taken only while `busy` is low. Results are not queued. They stay valid only on the single clock where `done` is high, and the requester must capture them on that clock.

Top module: `divq_unit`

## Requirements
- R1: After reset, `busy`, `done`, `result_valid` and `trap` are all low.
- R2: `start` is accepted on a rising edge where `busy` is low. `busy` is then high from the next clock until `done` has been shown. `done` is high for exactly one clock. That clock is the first after the accepting edge when the divisor is zero or the quotient overflows, and the 33rd after it otherwise. `busy` is low on the clock that follows `done`.
- R3: While `busy` is high, including the `done` clock, `start` and the operand inputs are ignored. The outputs shown with `done` belong to the accepted request, and no second operation begins.
- R4: An unsigned normal outcome gives `result` = {remainder[15:0], quotient[15:0]} and `result_valid` = 1. In `flags`, bit 3 is N and equals quotient bit 15, bit 2 is Z and is set when the 16-bit quotient is zero, and bit 1 (V) and bit 0 (C) are both 0.
- R5: In signed mode the quotient truncates toward zero and is negated when the operand signs differ. The remainder takes the sign of the dividend. The flags follow R4 applied to the signed 16-bit quotient.
- R6: A zero divisor gives `trap` = 1 with `done`, `result_valid` = 0, `flags` = 4'b0000 and `cycle_count` = 0, in either mode.
- R7: In unsigned mode, a quotient above 65535 gives `flags` = 4'b1010 (N and V set), `result_valid` = 0, `trap` = 0 and `cycle_count` = 6.
- R8: In signed mode, a quotient magnitude above 32767 gives `flags` = 4'b0010, `result_valid` = 0, `trap` = 0, and `cycle_count` = 24, plus 2 when the dividend is negative.
- R9: The unsigned normal cost starts at 12 and adds 15 steps to it. Each step looks at a 32-bit working value, which begins as the dividend, and a subtrahend equal to the divisor shifted left by 16. If the working value's MSB is set before its left shift, the step charges 4 and the working value becomes (value<<1) minus the subtrahend. Otherwise the working value is shifted left; if the shifted value is not below the subtrahend, the subtrahend is taken away from it and the step charges 6, and if it is below, the step charges 8.
- R10: The signed normal cost is built up as follows. Start at 116. Add 2 if the dividend is negative. Add 2 for each zero among bits 15 down to 1 of the quotient magnitude. Finally add 2 if the divisor is negative, or else 4 if only the dividend is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only while busy is low |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | An accepted request has not yet left its done clock |
| done | output | 1 | One-clock strobe; result, flags, trap and cycle_count are valid |
| result | output | 32 | {remainder, quotient} |
| result_valid | output | 1 | Write-back enable, high with done on a normal outcome |
| flags | output | 4 | {N, Z, V, C} |
| trap | output | 1 | Divide-by-zero trap request, high with done |
| cycle_count | output | 8 | Cycle cost charged by the modelled processor |

## Verification
On the `done` clock, `busy` is still high. A `start` presented on that same clock must therefore be dropped rather than begin a new division. The bench provokes this by holding `start` high, with different operands, from the clock after acceptance through the `done` clock. It then checks two things: the reported outcome is that of the first request, and `busy` is low on the following clock. The same collision is exercised for early-finishing requests, where acceptance and `done` are only one clock apart.

// File: rtl/divq_pkg.sv
package divq_pkg;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } ccr_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divq_state_e;

  localparam int unsigned CST_BASE          = 12;
  localparam int unsigned CST_U_MSB         = 4;
  localparam int unsigned CST_U_SUB         = 6;
  localparam int unsigned CST_U_NOSUB       = 8;
  localparam int unsigned CST_U_OVF         = 6;
  localparam int unsigned CST_S_NEGDVD      = 2;
  localparam int unsigned CST_S_OVF         = 12;
  localparam int unsigned CST_S_LOOP        = 104;
  localparam int unsigned CST_S_PER_ZERO    = 2;
  localparam int unsigned CST_S_NEGDVS      = 2;
  localparam int unsigned CST_S_NEGDVD_ONLY = 4;

endpackage

// File: rtl/divq_prep.sv
module divq_prep #(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 16
) (
  input  logic          signed_mode,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          dvd_neg,
  output logic          dvs_neg,
  output logic [DW-1:0] dvd_mag,
  output logic [VW-1:0] dvs_mag,
  output logic          dvs_zero,
  output logic          early_ovf
);
  localparam int unsigned HW = DW - VW + 1;

  logic u_ovf, s_ovf;

  assign dvd_neg  = signed_mode & dividend[DW-1];
  assign dvs_neg  = signed_mode & divisor[VW-1];
  assign dvd_mag  = dvd_neg ? (-dividend) : dividend;
  assign dvs_mag  = dvs_neg ? (-divisor) : divisor;
  assign dvs_zero = (divisor == '0);

  // quotient >= 2^VW  <=>  dividend[DW-1:VW] >= divisor
  assign u_ovf = DW'(dividend[DW-1:VW]) >= DW'(divisor);
  // |quotient| >= 2^(VW-1)  <=>  |dividend|[DW-1:VW-1] >= |divisor|
  assign s_ovf = HW'(dvd_mag[DW-1:VW-1]) >= HW'(dvs_mag);

  assign early_ovf = !dvs_zero && (signed_mode ? s_ovf : u_ovf);
endmodule

// File: rtl/divq_core.sv
module divq_core #(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] dvd,
  input  logic [VW-1:0] dvs,
  output logic [VW-1:0] quo_next,
  output logic [VW-1:0] rem_next
);
  logic [VW-1:0] rem_q;
  logic [DW-1:0] quo_q;
  logic [VW-1:0] dvs_q;
  logic [VW:0]   trial;
  logic [VW:0]   diff;
  logic          take;
  logic [DW-1:0] quo_shift;

  assign trial     = {rem_q, quo_q[DW-1]};
  assign diff      = trial - {1'b0, dvs_q};
  assign take      = ~diff[VW];
  assign rem_next  = take ? diff[VW-1:0] : trial[VW-1:0];
  assign quo_shift = {quo_q[DW-2:0], take};
  assign quo_next  = quo_shift[VW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dvd;
      dvs_q <= dvs;
    end else if (step) begin
      rem_q <= rem_next;
      quo_q <= quo_shift;
    end
  end
endmodule

// File: rtl/divq_cost.sv
module divq_cost
  import divq_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          signed_mode,
  input  logic          div_zero,
  input  logic          ovf,
  input  logic          dvd_neg,
  input  logic          dvs_neg,
  input  logic [DW-1:0] dvd_mag,
  input  logic [VW-1:0] dvs_mag,
  input  logic [VW-2:0] quo_hi,
  output logic [CW-1:0] cycles
);
  logic [DW-1:0] acc;
  logic [DW-1:0] dsh;
  int unsigned   u_tot, s_pre, s_tot, zeros;

  always_comb begin
    dsh   = {dvs_mag, {(DW-VW){1'b0}}};
    acc   = dvd_mag;
    u_tot = CST_BASE;
    for (int i = 0; i < int'(VW) - 1; i++) begin
      if (acc[DW-1]) begin
        acc   = (acc << 1) - dsh;
        u_tot = u_tot + CST_U_MSB;
      end else begin
        acc = acc << 1;
        if (acc >= dsh) begin
          acc   = acc - dsh;
          u_tot = u_tot + CST_U_SUB;
        end else begin
          u_tot = u_tot + CST_U_NOSUB;
        end
      end
    end

    s_pre = CST_BASE + (dvd_neg ? CST_S_NEGDVD : 32'd0);
    zeros = 0;
    for (int i = 0; i < int'(VW) - 1; i++) begin
      if (!quo_hi[i]) zeros = zeros + 1;
    end
    s_tot = s_pre + CST_S_PER_ZERO * zeros + CST_S_LOOP
          + (dvs_neg ? CST_S_NEGDVS : (dvd_neg ? CST_S_NEGDVD_ONLY : 32'd0));

    if (div_zero)
      cycles = '0;
    else if (ovf)
      cycles = signed_mode ? CW'(s_pre + CST_S_OVF) : CW'(CST_U_OVF);
    else
      cycles = signed_mode ? CW'(s_tot) : CW'(u_tot);
  end
endmodule

// File: rtl/divq_unit.sv
module divq_unit
  import divq_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          signed_mode,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          result_valid,
  output logic [3:0]    flags,
  output logic          trap,
  output logic [CW-1:0] cycle_count
);
  localparam int unsigned SW = $clog2(DW);
  localparam logic [SW-1:0] LAST_STEP = SW'(DW - 1);

  divq_state_e   state;
  logic [SW-1:0] step_cnt;

  // live operand conditioning
  logic          p_dn, p_sn, p_zero, p_ovf;
  logic [DW-1:0] p_dvd;
  logic [VW-1:0] p_dvs;

  divq_prep #(.DW(DW), .VW(VW)) u_prep (
    .signed_mode (signed_mode),
    .dividend    (dividend),
    .divisor     (divisor),
    .dvd_neg     (p_dn),
    .dvs_neg     (p_sn),
    .dvd_mag     (p_dvd),
    .dvs_mag     (p_dvs),
    .dvs_zero    (p_zero),
    .early_ovf   (p_ovf)
  );

  // latched request
  logic          sgn_q, dn_q, sn_q;
  logic [DW-1:0] dvd_q;
  logic [VW-1:0] dvs_q;

  logic accept, stepping, last;
  assign accept   = start && (state == ST_IDLE);
  assign stepping = (state == ST_RUN);
  assign last     = stepping && (step_cnt == LAST_STEP);

  logic [VW-1:0] q_mag, r_mag;

  divq_core #(.DW(DW), .VW(VW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (stepping),
    .dvd      (p_dvd),
    .dvs      (p_dvs),
    .quo_next (q_mag),
    .rem_next (r_mag)
  );

  // cost model fed by live operands at acceptance, latched ones afterwards
  logic          c_sgn, c_zero, c_ovf, c_dn, c_sn;
  logic [DW-1:0] c_dvd;
  logic [VW-1:0] c_dvs;
  logic [CW-1:0] c_cycles;

  always_comb begin
    if (state == ST_IDLE) begin
      c_sgn  = signed_mode;
      c_zero = p_zero;
      c_ovf  = p_ovf;
      c_dn   = p_dn;
      c_sn   = p_sn;
      c_dvd  = p_dvd;
      c_dvs  = p_dvs;
    end else begin
      c_sgn  = sgn_q;
      c_zero = 1'b0;
      c_ovf  = 1'b0;
      c_dn   = dn_q;
      c_sn   = sn_q;
      c_dvd  = dvd_q;
      c_dvs  = dvs_q;
    end
  end

  divq_cost #(.DW(DW), .VW(VW), .CW(CW)) u_cost (
    .signed_mode (c_sgn),
    .div_zero    (c_zero),
    .ovf         (c_ovf),
    .dvd_neg     (c_dn),
    .dvs_neg     (c_sn),
    .dvd_mag     (c_dvd),
    .dvs_mag     (c_dvs),
    .quo_hi      (q_mag[VW-1:1]),
    .cycles      (c_cycles)
  );

  // outcome formation
  logic [VW-1:0] q_fin, r_fin;
  ccr_t          early_f, norm_f;

  assign q_fin = (dn_q ^ sn_q) ? (-q_mag) : q_mag;
  assign r_fin = dn_q ? (-r_mag) : r_mag;

  always_comb begin
    early_f = '0;
    if (!p_zero) begin
      early_f.ovf = 1'b1;
      early_f.neg = !signed_mode;
    end
    norm_f       = '0;
    norm_f.neg   = q_fin[VW-1];
    norm_f.zero  = (q_fin == '0);
  end

  logic [DW-1:0] res_q;
  ccr_t          flg_q;
  logic          trp_q, wb_q;
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
      sgn_q    <= 1'b0;
      dn_q     <= 1'b0;
      sn_q     <= 1'b0;
      dvd_q    <= '0;
      dvs_q    <= '0;
      res_q    <= '0;
      flg_q    <= '0;
      trp_q    <= 1'b0;
      wb_q     <= 1'b0;
      cyc_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            sgn_q    <= signed_mode;
            dn_q     <= p_dn;
            sn_q     <= p_sn;
            dvd_q    <= p_dvd;
            dvs_q    <= p_dvs;
            step_cnt <= '0;
            if (p_zero || p_ovf) begin
              state <= ST_FIN;
              flg_q <= early_f;
              trp_q <= p_zero;
              wb_q  <= 1'b0;
              cyc_q <= c_cycles;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          step_cnt <= step_cnt + 1'b1;
          if (last) begin
            state <= ST_FIN;
            res_q <= {r_fin, q_fin};
            flg_q <= norm_f;
            trp_q <= 1'b0;
            wb_q  <= 1'b1;
            cyc_q <= c_cycles;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_FIN);
  assign result       = res_q;
  assign result_valid = done & wb_q;
  assign flags        = flg_q;
  assign trap         = done & trp_q;
  assign cycle_count  = cyc_q;
endmodule

// File: rtl/divq_unit_chk.sv
module divq_unit_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 16,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] result,
  input logic          result_valid,
  input logic [3:0]    flags,
  input logic          trap,
  input logic [CW-1:0] cycle_count
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_strobe_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid || trap) |-> done);

  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_wb_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (flags[1:0] == 2'b00) && (flags[3] == result[VW-1])
                     && (flags[2] == (result[VW-1:0] == '0)));

  p_trap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (!result_valid && flags == 4'b0000 && cycle_count == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flags[1]) |-> !result_valid);
endmodule

bind divq_unit divq_unit_chk #(.DW(DW), .VW(VW), .CW(CW)) u_chk (.*);

// File: tb/divq_unit_tb_top.sv
`timescale 1ns/1ps
module divq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, result_valid, trap;
  logic [31:0] result;
  logic [3:0]  flags;
  logic [7:0]  cycle_count;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  divq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .result(result), .result_valid(result_valid), .flags(flags),
    .trap(trap), .cycle_count(cycle_count)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ucost(input logic [31:0] a, input logic [15:0] b);
    logic [31:0] d = a;
    logic [31:0] s = {b, 16'h0000};
    int c = 12;
    for (int i = 0; i < 15; i++) begin
      if (d[31]) begin d = (d << 1) - s; c += 4; end
      else begin
        d = d << 1;
        if (d >= s) begin d = d - s; c += 6; end
        else c += 8;
      end
    end
    return c;
  endfunction

  // Expected outcome from the requirements
  task automatic ref_div(input bit sm, input logic [31:0] a, input logic [15:0] b,
                         output int lat, output logic [31:0] res, output bit wb,
                         output logic [3:0] fl, output bit tr, output int cyc,
                         output string rq, output string rc);
    longint sa, sb, ma, mb, q, qs, rs;
    logic [15:0] q16;
    int zeros;
    res = '0; wb = 0; tr = 0; fl = 4'b0000; cyc = 0; lat = 1;
    rq = "R6"; rc = "R6";
    if (b == 16'h0000) begin
      tr = 1;
      return;
    end
    if (!sm) begin
      q = longint'(a) / longint'(b);
      if (q > 65535) begin
        fl = 4'b1010; cyc = 6; rq = "R7"; rc = "R7";
      end else begin
        res = {16'(longint'(a) % longint'(b)), 16'(q)};
        q16 = 16'(q);
        fl = {q16[15], q16 == 16'h0, 2'b00};
        wb = 1; lat = 33; cyc = ucost(a, b); rq = "R4"; rc = "R9";
      end
    end else begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      ma = (sa < 0) ? -sa : sa;
      mb = (sb < 0) ? -sb : sb;
      q = ma / mb;
      if (q > 32767) begin
        fl = 4'b0010; cyc = 24 + ((sa < 0) ? 2 : 0); rq = "R8"; rc = "R8";
      end else begin
        qs = ((sa < 0) != (sb < 0)) ? -q : q;
        rs = sa - qs * sb;
        q16 = 16'(qs);
        res = {16'(rs), q16};
        fl = {q16[15], q16 == 16'h0, 2'b00};
        wb = 1; lat = 33; rq = "R5"; rc = "R10";
        zeros = 0;
        for (int i = 1; i < 16; i++) if (((q >> i) & 1) == 0) zeros++;
        cyc = 116 + ((sa < 0) ? 2 : 0) + 2 * zeros
            + ((sb < 0) ? 2 : ((sa < 0) ? 4 : 0));
      end
    end
  endtask

  // Called at a negedge with busy low; returns at a negedge with busy low.
  task automatic run_op(input bit sm, input logic [31:0] a, input logic [15:0] b,
                        input bit poke);
    int lat, cyc;
    logic [31:0] res;
    bit wb, tr;
    logic [3:0] fl;
    string rq, rc, rb;
    ref_div(sm, a, b, lat, res, wb, fl, tr, cyc, rq, rc);
    rb = poke ? "R3" : "R2";
    start = 1'b1; signed_mode = sm; dividend = a; divisor = b;
    @(negedge clk);
    if (poke) begin
      dividend = ~a; divisor = b + 16'h1; signed_mode = !sm;
    end else begin
      start = 1'b0;
    end
    for (int i = 1; i <= lat; i++) begin
      if (i > 1) @(negedge clk);
      chk(rb, "busy while running", {31'b0, busy}, 32'd1);
      chk(rb, "done timing", {31'b0, done}, {31'b0, i == lat});
      if (i == lat) begin
        chk(rq, "result_valid", {31'b0, result_valid}, {31'b0, wb});
        chk(rq, "trap", {31'b0, trap}, {31'b0, tr});
        chk(rq, "flags", {28'b0, flags}, {28'b0, fl});
        chk(rc, "cycle_count", {24'b0, cycle_count}, 32'(cyc));
        if (wb) chk(rq, "result", result, res);
      end
    end
    @(negedge clk);
    chk(rb, "busy after done", {31'b0, busy}, 32'd0);
    chk(rb, "done after done", {31'b0, done}, 32'd0);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", {31'b0, busy}, 32'd0);
    chk("R1", "done", {31'b0, done}, 32'd0);
    chk("R1", "result_valid", {31'b0, result_valid}, 32'd0);
    chk("R1", "trap", {31'b0, trap}, 32'd0);

    // unsigned
    run_op(0, 32'd100, 16'd7, 0);
    run_op(0, 32'h0000_0000, 16'd5, 0);
    run_op(0, 32'h0000_FFFF, 16'd1, 0);
    run_op(0, 32'hFFFE_FFFF, 16'hFFFF, 0);
    run_op(0, 32'h1234_5678, 16'h8000, 0);
    run_op(0, 32'h0001_0000, 16'd1, 0);
    run_op(0, 32'hFFFF_FFFF, 16'hFFFF, 0);
    run_op(0, 32'd5, 16'd0, 0);
    // signed
    run_op(1, -32'sd100, 16'd7, 0);
    run_op(1, 32'd100, -16'sd7, 0);
    run_op(1, -32'sd100, -16'sd7, 0);
    run_op(1, 32'd0, -16'sd3, 0);
    run_op(1, 32'd32767, 16'd1, 0);
    run_op(1, -32'sd32767, 16'd1, 0);
    run_op(1, 32'h0000_8000, 16'd1, 0);
    run_op(1, 32'hFFFF_8000, 16'd1, 0);
    run_op(1, 32'h8000_0000, 16'hFFFF, 0);
    run_op(1, 32'h1234, 16'd0, 0);
    // start held high while busy, including the done clock
    run_op(0, 32'd1000, 16'd33, 1);
    run_op(1, -32'sd5000, 16'd77, 1);
    run_op(0, 32'h0002_0000, 16'd2, 1);
    run_op(1, 32'd9, 16'd0, 1);
    // mixed operands
    for (int k = 0; k < 24; k++) begin
      logic [31:0] a;
      logic [15:0] b;
      bit sm;
      sm = k[0];
      b = 16'($urandom());
      a = $urandom();
      if (k % 3 != 0 && b != 0)
        a = 32'(longint'(a) % (longint'(b) << (sm ? 14 : 16)));
      run_op(sm, a, b, (k % 5) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule